// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard, clock and data, and turns the serial frames on them into scan-code bytes for the logic around it. It runs entirely on the fast system clock. Both keyboard lines first pass through a synchronizer. A prescaler then produces a slow sampling tick, and the keyboard clock is examined only on that tick. A falling edge seen between two consecutive ticks captures one bit from the data line.

Eleven captured bits make one frame. The frame holds a low start bit, eight data bits with the least significant bit first, an odd parity bit and a high stop bit. When a frame completes, the receiver raises a completion pulse. If the framing or the parity is wrong, an error pulse is raised with it. The byte output only moves on a good frame. A partial frame can be left behind by a lost clock edge. When no edge arrives within a programmable number of ticks, the partial frame is discarded, so the next frame starts aligned.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, and until a frame completes, `data_o` is 0x00 and both `done_o` and `err_o` are low.
- R2: The sampling tick is high for one system cycle in every `CLK_DIV` cycles. A bit is captured only when the synchronized keyboard clock is low on one tick and was high on the previous tick.
- R3: Bit order on the wire is start, d0 through d7, parity, stop. On a good frame, `data_o` becomes the byte assembled with the first data bit as bit 0.
- R4: `done_o` pulses high for exactly one system cycle per eleven captured bits, on good and bad frames alike, and never on a partial frame.
- R5: Parity is odd. The eight data bits plus the parity bit must contain an odd number of ones, otherwise `err_o` pulses together with `done_o`.
- R6: A start bit of 1 or a stop bit of 0 makes `err_o` pulse together with `done_o`. `err_o` is never high without `done_o`.
- R7: `data_o` keeps its previous value after a frame flagged by `err_o`.
- R8: If a frame has started and `GAP_TICKS` ticks pass without another captured bit, the collected bits are discarded. No completion is reported for them, and the next frame is received correctly.
- R9: A pause between bits that is shorter than `GAP_TICKS` ticks leaves the frame intact.
- R10: Good frames sent back to back are each reported with their own byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous |
| data_o | output | 8 | Last good scan-code byte |
| done_o | output | 1 | One-cycle pulse at the end of each 11-bit frame |
| err_o | output | 1 | One-cycle pulse, with `done_o`, for a bad frame |

## Verification
The bench builds the receiver with `CLK_DIV` = 4 and `GAP_TICKS` = 40. With these values, a keyboard half period of 16 system cycles is sampled on several ticks. A discarded partial frame then takes only a few hundred cycles to provoke, and a within-limit pause can be placed close to the timeout without crossing it. The defaults of 250 and 4000 use the same counter logic, only with wider counters, so the short values reach the same timeout and edge-detection corners in few cycles.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned FRAME_BITS = 11;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned BCNT_W     = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic                 stop;
    logic                 parity;
    logic [DATA_BITS-1:0] data;
    logic                 start;
  } ps2_frame_t;

  // start low, stop high, odd ones over data+parity
  function automatic logic frame_ok(ps2_frame_t f);
    return !f.start && f.stop && (^{f.parity, f.data});
  endfunction
endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;  // idle lines are high
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/ps2_rx_tick.sv
module ps2_rx_tick #(
  parameter int unsigned DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RELOAD;
      tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= RELOAD;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2_rx_gap.sv
module ps2_rx_gap #(
  parameter int unsigned LIMIT = 4000,
  localparam int unsigned GW   = $clog2(LIMIT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          bit_i,
  input  logic          active_i,
  output logic          flush_o,
  output logic [GW-1:0] gap_o
);
  localparam logic [GW-1:0] LAST = GW'(LIMIT - 1);

  logic [GW-1:0] gap_q;

  assign flush_o = tick_i && active_i && !bit_i && (gap_q == LAST);
  assign gap_o   = gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    gap_q <= '0;
    else if (bit_i || !active_i)    gap_q <= '0;
    else if (flush_o)               gap_q <= '0;
    else if (tick_i)                gap_q <= gap_q + 1'b1;
  end
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
  import ps2_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 kclk_i,
  input  logic                 kdat_i,
  input  logic                 flush_i,
  output logic                 bit_o,
  output logic                 active_o,
  output logic [BCNT_W-1:0]    bit_cnt_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam logic [BCNT_W-1:0] LAST_IDX = BCNT_W'(FRAME_BITS - 1);

  logic                  kclk_prev_q;
  logic [FRAME_BITS-2:0] shreg_q;
  logic [BCNT_W-1:0]     bcnt_q;
  logic                  fall;
  logic                  last_bit;
  ps2_frame_t            full;

  assign fall      = tick_i && kclk_prev_q && !kclk_i;
  assign last_bit  = (bcnt_q == LAST_IDX);
  assign full      = ps2_frame_t'({kdat_i, shreg_q});
  assign bit_o     = fall;
  assign active_o  = (bcnt_q != '0);
  assign bit_cnt_o = bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kclk_prev_q <= 1'b1;
      shreg_q     <= '0;
      bcnt_q      <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      data_o      <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (tick_i) kclk_prev_q <= kclk_i;
      if (fall) begin
        if (last_bit) begin
          shreg_q <= '0;
          bcnt_q  <= '0;
          done_o  <= 1'b1;
          err_o   <= !frame_ok(full);
          if (frame_ok(full)) data_o <= full.data;
        end else begin
          shreg_q <= {kdat_i, shreg_q[FRAME_BITS-2:1]};
          bcnt_q  <= bcnt_q + 1'b1;
        end
      end else if (flush_i) begin
        shreg_q <= '0;
        bcnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 250,
  parameter int unsigned GAP_TICKS   = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic [7:0] data_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int unsigned GW = $clog2(GAP_TICKS);

  logic [1:0]        sync_q;
  logic              tick;
  logic              bit_fall;
  logic              active;
  logic              flush;
  logic [BCNT_W-1:0] bit_cnt;
  logic [GW-1:0]     gap_cnt;

  ps2_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({ps2_dat_i, ps2_clk_i}),
    .q_o (sync_q)
  );

  ps2_rx_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i, .rst_ni,
    .tick_o (tick)
  );

  ps2_rx_gap #(.LIMIT(GAP_TICKS)) u_gap (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .bit_i    (bit_fall),
    .active_i (active),
    .flush_o  (flush),
    .gap_o    (gap_cnt)
  );

  ps2_rx_frame u_frame (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .kclk_i    (sync_q[0]),
    .kdat_i    (sync_q[1]),
    .flush_i   (flush),
    .bit_o     (bit_fall),
    .active_o  (active),
    .bit_cnt_o (bit_cnt),
    .done_o    (done_o),
    .err_o     (err_o),
    .data_o    (data_o)
  );
endmodule

// File: rtl/ps2_frame_rx_chk.sv
module ps2_frame_rx_chk #(
  parameter int unsigned GAP_TICKS = 4000,
  parameter int unsigned BW        = 4,
  parameter int unsigned GW        = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick,
  input logic          flush,
  input logic [BW-1:0] bit_cnt,
  input logic [GW-1:0] gap_cnt,
  input logic          done_o,
  input logic          err_o,
  input logic [7:0]    data_o
);
  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  a_r3_bit_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt < BW'(11));

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tick));

  a_r6_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r7_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && !err_o) |-> $stable(data_o));

  a_r8_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (bit_cnt == '0));

  a_r8_gap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_cnt < GW'(GAP_TICKS));
endmodule

bind ps2_frame_rx ps2_frame_rx_chk #(
  .GAP_TICKS (GAP_TICKS),
  .BW        (ps2_rx_pkg::BCNT_W),
  .GW        ($clog2(GAP_TICKS))
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick    (tick),
  .flush   (flush),
  .bit_cnt (bit_cnt),
  .gap_cnt (gap_cnt),
  .done_o  (done_o),
  .err_o   (err_o),
  .data_o  (data_o)
);

// File: tb/ps2_frame_rx_tb.sv
module ps2_frame_rx_tb_top;
  localparam int HALF = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kclk = 1'b1;
  logic       kdat = 1'b1;
  logic [7:0] data;
  logic       done, err;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  int wide_done = 0;
  logic prev_done = 1'b0;

  always #10 clk = ~clk;

  ps2_frame_rx #(.CLK_DIV(4), .GAP_TICKS(40), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(kclk), .ps2_dat_i(kdat),
    .data_o(data), .done_o(done), .err_o(err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (done && prev_done) wide_done++;
      prev_done <= done;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk(logic [7:0] b, bit bad_par, bit start, bit stop);
    return {stop, (~^b) ^ bad_par, b, start};
  endfunction

  task automatic send_bits(logic [10:0] f, int n, int pause_at, int pause);
    for (int i = 0; i < n; i++) begin
      if (i == pause_at) repeat (pause) @(posedge clk);
      kdat = f[i];
      repeat (HALF) @(posedge clk);
      kclk = 1'b0;
      repeat (HALF) @(posedge clk);
      kclk = 1'b1;
    end
    kdat = 1'b1;
    repeat (HALF + 8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_good(logic [7:0] b, string req);
    int d0 = done_cnt, e0 = err_cnt;
    send_bits(mk(b, 0, 0, 1), 11, -1, 0);
    check({req, " done"}, done_cnt - d0, 1);
    check({req, " err"}, err_cnt - e0, 0);
    check({req, " data"}, data, b);
  endtask

  task automatic t_bad(logic [10:0] f, logic [7:0] keep, string req);
    int d0 = done_cnt, e0 = err_cnt;
    send_bits(f, 11, -1, 0);
    check({req, " done"}, done_cnt - d0, 1);
    check({req, " err"}, err_cnt - e0, 1);
    check("R7 data kept", data, keep);
  endtask

  task automatic t_reset;
    check("R1 data", data, 8'h00);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
  endtask

  task automatic t_gap_flush;
    int d0 = done_cnt;
    send_bits(mk(8'h5A, 0, 0, 1), 5, -1, 0);
    repeat (400) @(posedge clk);
    @(negedge clk);
    check("R8 no done on partial", done_cnt - d0, 0);
    t_good(8'hA5, "R8 after flush");
  endtask

  task automatic t_short_pause;
    int d0 = done_cnt, e0 = err_cnt;
    send_bits(mk(8'h3C, 0, 0, 1), 11, 6, 60);
    check("R9 done", done_cnt - d0, 1);
    check("R9 err", err_cnt - e0, 0);
    check("R9 data", data, 8'h3C);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_good(8'h1C, "R2 R3 first");
    t_good(8'h00, "R5 zero byte");
    t_good(8'hFF, "R5 all ones");
    t_good(8'h80, "R3 msb");
    t_good(8'h01, "R3 lsb");
    t_bad(mk(8'h66, 1, 0, 1), 8'h01, "R5 bad parity");
    t_bad(mk(8'h66, 0, 1, 1), 8'h01, "R6 bad start");
    t_bad(mk(8'h66, 0, 0, 0), 8'h01, "R6 bad stop");
    t_gap_flush();
    t_short_pause();
    t_good(8'hF0, "R10 seq a");
    t_good(8'h74, "R10 seq b");
    check("R4 done one cycle", wide_done, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule